// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and each bank has its own small register group. From the register bus, software can read the pin levels, choose each pin's direction, raise or lower output latches through separate set and clear ports, and enable rising and/or falling edge capture. Captured edges sit in a sticky status register until software writes a 1 to them.

The bank register groups are interleaved. Three banks share each 256-byte page, with the banks placed 4 bytes apart inside the page. An optional per-bank mask decides which pending edges reach the processor. Pins 0 and 1 of bank 0 each drive a dedicated interrupt line. Every other pending edge, in any bank, drives one shared line. Pin inputs pass through a two-flop synchronizer before they are read or examined for edges.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The base of bank n is ((n / 3) << 8) + ((n % 3) << 2). Within a bank, the register offsets from the base are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48 and mask 0x9C. Reads of any other address return zero, and writes to any other address change nothing. This covers non-word-aligned addresses and banks at or beyond NUM_BANKS.
- R2: Each 1 written to the set register drives that pin's output latch (pad_out) high, and each 1 written to the clear register drives it low. Bits written as 0 leave the latch alone. Both registers read as zero.
- R3: The level register returns the pad_in value from two clock edges before the read is sampled. Each pin passes through two synchronizer flops.
- R4: A direction bit of 1 drives pad_oe high for that pin, and 0 drives it low. The direction register reads back what was written. For global pins INV_LO..INV_HI (default 86..89, which is bank 2 bits 22..25), pad_oe is the inverse of the direction bit.
- R5: An edge status bit becomes 1 when its synchronized pin rises and its rising enable is set, or when it falls and its falling enable is set. Setting both enables catches either edge. The bit is visible, together with any interrupt it raises, after the third clock edge following the pad_in change. No bit is set for an edge that is not enabled.
- R6: Edge status bits are sticky. Writing 1 clears a bit, writing 0 has no effect, and writing all ones clears the whole bank.
- R7: If a new edge and a write-1-to-clear reach the same status bit on the same clock edge, the bit stays 1.
- R8: The mask register resets to all ones, which leaves every pin unmasked. A mask bit of 0 keeps that pin's pending edge off all interrupt outputs. The status bit is still recorded and can still be read.
- R9: irq_pin0 and irq_pin1 follow the unmasked pending status of bank 0 bits 0 and 1. irq_mux is high while any other unmasked pending bit is set in any bank.
- R10: Reset (synchronous, active-low) clears the direction, enable, status and output latches. It sets the masks to all ones and holds all interrupts low.
- R11: Read data is registered. bus_rdata shows the addressed value from the clock edge that samples bus_rd, and a write takes effect on the clock edge that samples bus_wr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 224 | Pin input levels, 32 per bank |
| pad_out | output | 224 | Output latch values |
| pad_oe | output | 224 | Output enables |
| irq_pin0 | output | 1 | Dedicated interrupt for bank 0 pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for bank 0 pin 1 |
| irq_mux | output | 1 | Shared interrupt for all other pins |

## Verification
Register writes, and the pad_out and pad_oe values they set, are due on the clock edge that samples the strobe, and read data appears in the same edge. The bench drives on falling edges and samples at the next falling edge. A pad_in change shows in the level register two edges later and in the edge status and interrupt lines three edges later. The bench counts those edges explicitly: it samples an interrupt once after the second edge, expecting it low, and once after the third, expecting it high. It also performs a read in the same cycle as a pin change, expecting the old level. For the clear-versus-edge race, the clear write is placed on the exact edge where the new edge is captured.

// File: rtl/gpio_pkg.sv
// Package: shared constants and types for the banked GPIO controller.
// Assumes 32 pins per bank and register groups of at most 8 kinds.
package gpio_pkg;
    localparam int BANK_PINS = 32;

    // Register kinds; the numeric order equals (word offset / 3) within a page.
    typedef enum logic [3:0] {
        KIND_LEVEL = 4'd0,
        KIND_DIR   = 4'd1,
        KIND_SET   = 4'd2,
        KIND_CLR   = 4'd3,
        KIND_RISE  = 4'd4,
        KIND_FALL  = 4'd5,
        KIND_STAT  = 4'd6,
        KIND_MASK  = 4'd7,
        KIND_NONE  = 4'd8
    } reg_kind_e;

    typedef logic [BANK_PINS-1:0] word_t;
endpackage

// File: rtl/gpio_addr_dec.sv
// Module: address decoder. It maps a byte address to a bank index and a
// register kind. Three banks share each 256-byte page at a 4-byte stride.
// Assumes ADDR_W >= 9. Unaligned or out-of-range addresses give KIND_NONE.
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 7,
    parameter bit HAS_MASK  = 1'b1,
    parameter int BANK_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [BANK_W-1:0] bank
);
    localparam int MASK_WORD = 'h9C / 4;
    localparam int LAST_WORD = 7 * 3;

    int page_i;
    int word_i;
    int sub_i;
    int bank_i;

    // Split the address into page, word and sub-bank, then range-check.
    always_comb begin
        page_i = int'(addr[ADDR_W-1:8]);
        word_i = int'(addr[7:2]);
        sub_i  = 0;
        kind   = KIND_NONE;
        if (addr[1:0] == 2'b00) begin
            if (word_i < LAST_WORD) begin
                kind  = reg_kind_e'(4'(word_i / 3));
                sub_i = word_i % 3;
            end else if (HAS_MASK && word_i >= MASK_WORD && word_i < MASK_WORD + 3) begin
                kind  = KIND_MASK;
                sub_i = word_i - MASK_WORD;
            end
        end
        bank_i = page_i * 3 + sub_i;
        if (bank_i >= NUM_BANKS) begin
            kind = KIND_NONE;
        end
        bank = BANK_W'(bank_i);
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: one 32-pin bank. It holds the synchronizer, direction, output
// latch, edge enables, sticky status and optional mask. It assumes at most
// one register write per cycle, given as a kind plus data.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter word_t INV_BITS = '0,
    parameter bit    HAS_MASK = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  word_t     pin_in,
    input  logic      wr_en,
    input  reg_kind_e wr_kind,
    input  word_t     wr_data,
    output word_t     level,
    output word_t     dir_q,
    output word_t     rise_en,
    output word_t     fall_en,
    output word_t     status,
    output word_t     mask_q,
    output word_t     out_q,
    output word_t     oe
);
    word_t sync1, sync2, prev;
    word_t edge_hit;
    word_t clr_bits;

    // Two-flop synchronizer plus a delayed copy for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Enabled rising or falling transitions of the synchronized pins.
    always_comb edge_hit = (sync2 & ~prev & rise_en) | (~sync2 & prev & fall_en);

    // Write-one-to-clear bits for this cycle.
    always_comb clr_bits = (wr_en && wr_kind == KIND_STAT) ? wr_data : '0;

    // Control registers and output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            rise_en <= '0;
            fall_en <= '0;
            out_q   <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                KIND_DIR:  dir_q   <= wr_data;
                KIND_RISE: rise_en <= wr_data;
                KIND_FALL: fall_en <= wr_data;
                KIND_SET:  out_q   <= out_q | wr_data;
                KIND_CLR:  out_q   <= out_q & ~wr_data;
                default: ;
            endcase
        end
    end

    // Sticky status: a new edge has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | edge_hit;
    end

    generate
        if (HAS_MASK) begin : g_mask
            // Interrupt mask register, unmasked after reset.
            always_ff @(posedge clk) begin
                if (!rst_n)                            mask_q <= '1;
                else if (wr_en && wr_kind == KIND_MASK) mask_q <= wr_data;
            end
        end else begin : g_nomask
            assign mask_q = '1;
        end
    endgenerate

    assign level = sync2;
    assign oe    = dir_q ^ INV_BITS;
endmodule

// File: rtl/gpio_irq_merge.sv
// Module: combines the unmasked pending bits of all banks into two dedicated
// lines (bank 0 bits 0 and 1) and one shared line for everything else.
module gpio_irq_merge
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 7
) (
    input  word_t pend [NUM_BANKS],
    output logic  irq_pin0,
    output logic  irq_pin1,
    output logic  irq_mux
);
    logic [NUM_BANKS-1:0] part;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_part
            if (b == 0) begin : g_first
                // Bank 0 contributes its bits above the two dedicated pins.
                assign part[b] = |pend[b][BANK_PINS-1:2];
            end else begin : g_rest
                // Other banks contribute every pending bit.
                assign part[b] = |pend[b];
            end
        end
    endgenerate

    assign irq_pin0 = pend[0][0];
    assign irq_pin1 = pend[0][1];
    assign irq_mux  = |part;
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller. It decodes the register bus,
// dispatches writes to the banks, returns registered read data and merges
// the interrupts. It assumes single-cycle strobes and no simultaneous read
// and write to volatile registers.
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 7,
    parameter int ADDR_W    = 12,
    parameter bit HAS_MASK  = 1'b1,
    parameter bit INV_EN    = 1'b1,
    parameter int INV_LO    = 86,
    parameter int INV_HI    = 89
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [BANK_PINS-1:0]           bus_wdata,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    output logic [BANK_PINS-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pad_in,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_out,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_oe,
    output logic                           irq_pin0,
    output logic                           irq_pin1,
    output logic                           irq_mux
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    // Pins of bank b whose direction sense is reversed.
    function automatic word_t inv_bits(input int b);
        word_t r;
        for (int i = 0; i < BANK_PINS; i++) begin
            r[i] = INV_EN && (b * BANK_PINS + i >= INV_LO) && (b * BANK_PINS + i <= INV_HI);
        end
        return r;
    endfunction

    reg_kind_e         dec_kind;
    logic [BANK_W-1:0] dec_bank;

    word_t lvl_w  [NUM_BANKS];
    word_t dir_w  [NUM_BANKS];
    word_t rise_w [NUM_BANKS];
    word_t fall_w [NUM_BANKS];
    word_t stat_w [NUM_BANKS];
    word_t mask_w [NUM_BANKS];
    word_t pend_w [NUM_BANKS];

    gpio_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .HAS_MASK (HAS_MASK),
        .BANK_W   (BANK_W)
    ) u_dec (
        .addr(bus_addr),
        .kind(dec_kind),
        .bank(dec_bank)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic bank_wr;
            // Write strobe for this bank only.
            assign bank_wr = bus_wr && (dec_kind != KIND_NONE) && (int'(dec_bank) == b);

            gpio_bank #(
                .INV_BITS(inv_bits(b)),
                .HAS_MASK(HAS_MASK)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_in (pad_in[b*BANK_PINS +: BANK_PINS]),
                .wr_en  (bank_wr),
                .wr_kind(dec_kind),
                .wr_data(bus_wdata),
                .level  (lvl_w[b]),
                .dir_q  (dir_w[b]),
                .rise_en(rise_w[b]),
                .fall_en(fall_w[b]),
                .status (stat_w[b]),
                .mask_q (mask_w[b]),
                .out_q  (pad_out[b*BANK_PINS +: BANK_PINS]),
                .oe     (pad_oe[b*BANK_PINS +: BANK_PINS])
            );

            assign pend_w[b] = stat_w[b] & mask_w[b];
        end
    endgenerate

    // Registered read mux; unmapped and write-only registers read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (dec_kind)
                KIND_LEVEL: bus_rdata <= lvl_w[dec_bank];
                KIND_DIR:   bus_rdata <= dir_w[dec_bank];
                KIND_RISE:  bus_rdata <= rise_w[dec_bank];
                KIND_FALL:  bus_rdata <= fall_w[dec_bank];
                KIND_STAT:  bus_rdata <= stat_w[dec_bank];
                KIND_MASK:  bus_rdata <= mask_w[dec_bank];
                default:    bus_rdata <= '0;
            endcase
        end
    end

    gpio_irq_merge #(
        .NUM_BANKS(NUM_BANKS)
    ) u_irq (
        .pend    (pend_w),
        .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1),
        .irq_mux (irq_mux)
    );
endmodule

// File: rtl/gpio_ctrl_chk.sv
// Module: assertion checker for gpio_bank_ctrl, attached through bind.
// Assumes reset is held for at least one clock edge at start-up.
module gpio_ctrl_chk #(
    parameter int NUM_BANKS = 7,
    parameter int ADDR_W    = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_wdata,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [31:0]               bus_rdata,
    input logic [NUM_BANKS*32-1:0]   pad_in,
    input logic [NUM_BANKS*32-1:0]   pad_out,
    input logic                      irq_pin0,
    input logic                      irq_pin1,
    input logic                      irq_mux
);
    localparam int LAST_PAGE = (NUM_BANKS - 1) / 3;

    logic [1:0] warm;

    // Cycles since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 3)  warm <= warm + 2'd1;
    end

    // R2: bits written to bank 0 set register are high next cycle.
    a_r2_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h018)) |=>
        ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R2: bits written to bank 0 clear register are low next cycle.
    a_r2_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h024)) |=>
        ((pad_out[31:0] & $past(bus_wdata)) == 32'd0));

    // R3: bank 0 level read returns pad_in from two edges before the read edge.
    a_r3_level_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && bus_rd && bus_addr == '0) |=>
        (bus_rdata == $past(pad_in[31:0], 3)));

    // R1: addresses in pages beyond the last bank read as zero.
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr[ADDR_W-1:8]) > LAST_PAGE) |=> (bus_rdata == 32'd0));

    // R10: at the first edge after reset, outputs show the reset state.
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd0) |-> (pad_out == '0 && !irq_pin0 && !irq_pin1 && !irq_mux));
endmodule

bind gpio_bank_ctrl gpio_ctrl_chk #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .irq_pin0 (irq_pin0),
    .irq_pin1 (irq_pin1),
    .irq_mux  (irq_mux)
);

// File: tb/gpio_bank_ctrl_tb.sv
// Directed bench for gpio_bank_ctrl: one task per scenario.
module gpio_bank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 7;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq_pin0, irq_pin1, irq_mux;

    int n_checks = 0;
    int n_fails  = 0;

    gpio_bank_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .irq_pin0 (irq_pin0),
        .irq_pin1 (irq_pin1),
        .irq_mux  (irq_mux)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R10", "pad_out bank0", pad_out[31:0], 32'h0);
        check("R10", "pad_oe bank2 inverted pins", pad_oe[95:64], 32'h03C0_0000);
        check("R10", "irqs", {29'd0, irq_pin0, irq_pin1, irq_mux}, 32'h0);
        rd(12'h00C, v); check("R10", "dir bank0", v, 32'h0);
        rd(12'h09C, v); check("R10", "mask bank0", v, 32'hFFFF_FFFF);
        rd(12'h048, v); check("R10", "status bank0", v, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        wr(12'h018, 32'h0000_00F0);
        check("R2", "set F0", pad_out[31:0], 32'h0000_00F0);
        wr(12'h018, 32'h0000_0003);
        check("R2", "set 03 keeps others", pad_out[31:0], 32'h0000_00F3);
        wr(12'h024, 32'h0000_0010);
        check("R2", "clear 10", pad_out[31:0], 32'h0000_00E3);
        rd(12'h018, v); check("R2", "set reads zero", v, 32'h0);
        rd(12'h024, v); check("R2", "clear reads zero", v, 32'h0);
        wr(12'h218, 32'h8000_0001);
        check("R2", "bank6 set", pad_out[223:192], 32'h8000_0001);
        check("R11", "bank0 unaffected by bank6 write", pad_out[31:0], 32'h0000_00E3);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(12'h110, 32'hA5A5_0000);
        rd(12'h110, v); check("R1", "dir bank4 readback", v, 32'hA5A5_0000);
        check("R1", "pad_oe bank4", pad_oe[159:128], 32'hA5A5_0000);
        rd(12'h10C, v); check("R1", "dir bank3 untouched", v, 32'h0);
        wr(12'h210, 32'hFFFF_FFFF);
        rd(12'h210, v); check("R1", "bank7 dir reads zero", v, 32'h0);
        check("R1", "bank6 oe unchanged", pad_oe[223:192], 32'h0);
        rd(12'h00D, v); check("R1", "unaligned reads zero", v, 32'h0);
        rd(12'h300, v); check("R1", "page3 reads zero", v, 32'h0);
    endtask

    task automatic t_dir_inv;
        logic [31:0] v;
        wr(12'h014, 32'h0240_0001);
        rd(12'h014, v); check("R4", "dir bank2 readback", v, 32'h0240_0001);
        check("R4", "pad_oe bank2 with inverted 86..89", pad_oe[95:64], 32'h0180_0001);
    endtask

    task automatic t_level;
        logic [31:0] v;
        @(negedge clk);
        pad_in[31:0] = 32'h1234_5678;
        bus_addr = 12'h000; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R3", "level same-cycle read is old", bus_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R3", "level two edges later", bus_rdata, 32'h1234_5678);
        pad_in[191:160] = 32'hCAFE_0042;
        idle(3);
        rd(12'h108, v); check("R3", "level bank5", v, 32'hCAFE_0042);
        pad_in = '0;
        idle(4);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(12'h034, 32'h0000_0005);
        wr(12'h040, 32'h0000_0006);
        @(negedge clk); pad_in[35:32] = 4'hF;
        idle(4);
        rd(12'h04C, v); check("R5", "rising captures bits 0,2", v, 32'h0000_0005);
        check("R9", "irq_mux from bank1", {31'd0, irq_mux}, 32'h1);
        wr(12'h04C, 32'hFFFF_FFFF);
        rd(12'h04C, v); check("R6", "all ones clears bank", v, 32'h0);
        @(negedge clk); pad_in[35:32] = 4'h0;
        idle(4);
        rd(12'h04C, v); check("R5", "falling captures bits 1,2", v, 32'h0000_0006);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(12'h04C, 32'h0000_0002);
        rd(12'h04C, v); check("R6", "w1c bit1", v, 32'h0000_0004);
        wr(12'h04C, 32'h0000_0000);
        rd(12'h04C, v); check("R6", "write zero no effect", v, 32'h0000_0004);
        wr(12'h04C, 32'hFFFF_FFFF);
        rd(12'h04C, v); check("R6", "all ones clear", v, 32'h0);
        check("R9", "irq_mux drops", {31'd0, irq_mux}, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(12'h030, 32'h0000_0023);
        @(negedge clk); pad_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5", "irq_pin0 low after 2 edges", {31'd0, irq_pin0}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R5", "irq_pin0 high after 3 edges", {31'd0, irq_pin0}, 32'h1);
        check("R9", "irq_mux stays low for pin0", {31'd0, irq_mux}, 32'h0);
        @(negedge clk); pad_in[1] = 1'b1;
        idle(3);
        check("R9", "irq_pin1", {31'd0, irq_pin1}, 32'h1);
        check("R9", "irq_mux low for pin1", {31'd0, irq_mux}, 32'h0);
        @(negedge clk); pad_in[5] = 1'b1;
        idle(3);
        check("R9", "irq_mux for pin5", {31'd0, irq_mux}, 32'h1);
        wr(12'h09C, ~32'h0000_0021);
        check("R8", "masked irqs", {29'd0, irq_pin0, irq_pin1, irq_mux}, 32'h2);
        rd(12'h048, v); check("R8", "status kept under mask", v, 32'h0000_0023);
        wr(12'h09C, 32'hFFFF_FFFF);
        check("R8", "unmask restores", {29'd0, irq_pin0, irq_pin1, irq_mux}, 32'h7);
        wr(12'h030, 32'h0);
        wr(12'h048, 32'hFFFF_FFFF);
        check("R9", "all irqs clear", {29'd0, irq_pin0, irq_pin1, irq_mux}, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        wr(12'h030, 32'h0000_0008);
        wr(12'h03C, 32'h0000_0008);
        @(negedge clk); pad_in[3] = 1'b1;
        idle(4);
        rd(12'h048, v); check("R5", "bit3 set on rise", v, 32'h0000_0008);
        @(negedge clk); pad_in[3] = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_addr = 12'h048; bus_wdata = 32'h0000_0008; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        rd(12'h048, v); check("R7", "edge wins over clear", v, 32'h0000_0008);
        wr(12'h048, 32'h0000_0008);
        rd(12'h048, v); check("R7", "plain clear", v, 32'h0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_map();
        t_dir_inv();
        t_level();
        t_edge();
        t_w1c();
        t_irq();
        t_race();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule